// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block gathers condition signals from two status sources, a clock-synthesiser lock monitor and a converter over-range detector, into a latched status register. A flag rises the cycle after its source is seen high and stays set until software reads the status register. That read returns the flags and clears them in the same cycle. A mask register enables each source. A flag whose mask bit is zero never latches and always reads as zero.

A summary of the unmasked flags drives one interrupt pin. A two-bit mode field selects how the pin signals. It can be an actively driven high-true output, an actively driven low-true output, or an open-drain low-true output. In open-drain mode the block only ever pulls the pin low or releases it, so an external pull-up has to supply the high level. Registers are accessed through a plain address / read strobe / write strobe port, and read data is returned in the same cycle as the strobe.

Top module: `irq_status_ctrl`

## Requirements
- R1: A status flag, once set, keeps reading 1 on every later cycle until a read of the status register (address 0x20) clears it.
- R2: A read strobe at address 0x20 returns the current flags and clears all of them at that clock edge. Reads at any other address leave the flags unchanged.
- R3: A source whose mask bit is 0 does not set its flag. Its flag reads 0 and does not cause an interrupt.
- R4: Status bit 7 is the lock-loss flag and status bit 1 is the over-range flag. All other status bits read 0. The register resets to 0x00 and ignores writes.
- R5: An event that is high in the same cycle as a clearing read leaves its flag set after the read.
- R6: The mask register sits at address 0x21. It is read/write and resets to 0x00. Only bits 7 and 1 are writable, and a 1 in a bit enables the matching source. The other bits read 0.
- R7: The pin-mode field is bits [1:0] at address 0x22. It resets to 00 and reads back the value last written, including 11. Bits [7:2] read 0.
- R8: In mode 00, and in the reserved mode 11, the pin is driven (irq_oe=1) and irq_o equals the pending state.
- R9: In mode 01 the pin is driven (irq_oe=1) and irq_o is the inverse of the pending state.
- R10: In mode 10, irq_o is always 0 and irq_oe equals the pending state, so the pin is pulled low only while an interrupt is pending.
- R11: The interrupt is pending when any unmasked flag is set. The pin follows the registered flags with no further delay, which means it changes one cycle after the event that sets a flag.
- R12: Event inputs are sampled as levels on every clock. A source that is still high after a clearing read sets its flag again at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 8 | Register address |
| reg_rd | input | 1 | Read strobe; at 0x20 it clears the flags |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_rd is high, 0 otherwise |
| lock_lost | input | 1 | Lock-loss condition level |
| over_range | input | 1 | Over-range condition level |
| irq_o | output | 1 | Interrupt pin data value |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The hardest case to reach from the ports is a read that collides with an event. The clearing read and a fresh rising event on an enabled source have to land in the same cycle, and the mask must be in a known state. A second hard case is a mask change while a flag is already set. The stimulus reaches both with directed sequences: it enables both sources, raises one event, and strobes a status read on exactly that cycle. Random traffic then follows, with sparse events, frequent reads of all three addresses, and occasional mask and mode rewrites. It is checked every cycle against a bench model of the flags, mask and mode.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 8;

    typedef enum logic [1:0] {
        PIN_HIGH = 2'b00,
        PIN_LOW  = 2'b01,
        PIN_OD   = 2'b10,
        PIN_RSVD = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic [REG_W-1:0] mask;
        pin_mode_e        mode;
    } cfg_t;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_stat_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h21,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h22,
    parameter logic [REG_W-1:0]  WMASK     = 8'h82
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  mask_q,
    output pin_mode_e         mode_q
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && addr == MASK_ADDR) begin
            cfg_d.mask = wdata & WMASK;
        end
        if (wr_en && addr == MODE_ADDR) begin
            cfg_d.mode = pin_mode_e'(wdata[1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{mask: '0, mode: PIN_HIGH};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mask_q = cfg_q.mask;
    assign mode_q = cfg_q.mode;

    AST_MASK_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q & ~WMASK) == '0); // R6

endmodule

// File: rtl/irq_status_latch.sv
module irq_status_latch
    import irq_stat_pkg::*;
#(
    parameter logic [REG_W-1:0] SRC_MAP = 8'h82
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [REG_W-1:0] ev_vec,
    input  logic [REG_W-1:0] mask,
    output logic [REG_W-1:0] status_q,
    output logic             pending
);

    logic [REG_W-1:0] status_d;

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (SRC_MAP[i]) begin : g_src
            // keep unless cleared, then OR in a fresh event; gate by enable
            assign status_d[i] = ((status_q[i] & ~clr) | ev_vec[i]) & mask[i];
        end else begin : g_rsvd
            assign status_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    assign pending = |(status_q & mask);

    for (genvar i = 0; i < REG_W; i++) begin : g_chk
        if (SRC_MAP[i]) begin : g_a
            AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (status_q[i] && !clr && mask[i]) |=> status_q[i]); // R1
            AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (clr && !ev_vec[i]) |=> !status_q[i]); // R2
            AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                !mask[i] |=> !status_q[i]); // R3
            AST_KEEP_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
                (clr && ev_vec[i] && mask[i]) |=> status_q[i]); // R5
        end else begin : g_r
            AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                !status_q[i]); // R4
        end
    end

endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv
    import irq_stat_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pin_mode_e mode,
    input  logic      pending,
    output logic      irq_o,
    output logic      irq_oe
);

    always_comb begin
        unique case (mode)
            PIN_LOW: begin
                irq_o  = ~pending;
                irq_oe = 1'b1;
            end
            PIN_OD: begin
                irq_o  = 1'b0;
                irq_oe = pending;
            end
            default: begin
                irq_o  = pending;
                irq_oe = 1'b1;
            end
        endcase
    end

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PIN_OD) |-> !(irq_oe && irq_o)); // R10
    AST_PUSHPULL_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != PIN_OD) |-> irq_oe); // R8

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_stat_pkg::*;
#(
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h20,
    parameter logic [ADDR_W-1:0] MASK_ADDR   = 8'h21,
    parameter logic [ADDR_W-1:0] MODE_ADDR   = 8'h22,
    parameter int                LOCK_BIT    = 7,
    parameter int                OVR_BIT     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              lock_lost,
    input  logic              over_range,
    output logic              irq_o,
    output logic              irq_oe
);

    localparam logic [REG_W-1:0] SRC_MAP =
        (REG_W'(1) << LOCK_BIT) | (REG_W'(1) << OVR_BIT);

    logic [REG_W-1:0] mask_q;
    pin_mode_e        mode_q;
    logic [REG_W-1:0] status_q;
    logic [REG_W-1:0] ev_vec;
    logic             pending;
    logic             clr;

    always_comb begin
        ev_vec           = '0;
        ev_vec[LOCK_BIT] = lock_lost;
        ev_vec[OVR_BIT]  = over_range;
    end

    assign clr = reg_rd && (reg_addr == STATUS_ADDR);

    irq_cfg_regs #(
        .MASK_ADDR (MASK_ADDR),
        .MODE_ADDR (MODE_ADDR),
        .WMASK     (SRC_MAP)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (reg_addr),
        .wr_en  (reg_wr),
        .wdata  (reg_wdata),
        .mask_q (mask_q),
        .mode_q (mode_q)
    );

    irq_status_latch #(
        .SRC_MAP (SRC_MAP)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .ev_vec   (ev_vec),
        .mask     (mask_q),
        .status_q (status_q),
        .pending  (pending)
    );

    irq_pin_drv u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_q),
        .pending (pending),
        .irq_o   (irq_o),
        .irq_oe  (irq_oe)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (reg_addr == STATUS_ADDR) begin
                reg_rdata = status_q & mask_q;
            end else if (reg_addr == MASK_ADDR) begin
                reg_rdata = mask_q;
            end else if (reg_addr == MODE_ADDR) begin
                reg_rdata = {{(REG_W-2){1'b0}}, mode_q};
            end
        end
    end

    AST_PENDING_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_lost && mask_q[LOCK_BIT] && !(reg_wr && reg_addr == MASK_ADDR)) |=> pending); // R11
    AST_RELOAD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && over_range && mask_q[OVR_BIT]) |=> status_q[OVR_BIT]); // R12

endmodule

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       lock_lost = 1'b0;
    logic       over_range = 1'b0;
    logic       irq_o;
    logic       irq_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] m_st = 8'h00;
    logic [7:0] m_mask = 8'h00;
    logic [1:0] m_mode = 2'b00;

    always #2 clk = ~clk;

    irq_status_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_rd     (reg_rd),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .lock_lost  (lock_lost),
        .over_range (over_range),
        .irq_o      (irq_o),
        .irq_oe     (irq_oe)
    );

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        if (a == 8'h20) return m_st & m_mask;
        if (a == 8'h21) return m_mask;
        if (a == 8'h22) return {6'b0, m_mode};
        return 8'h00;
    endfunction

    function automatic logic [1:0] exp_pin();
        logic p;
        p = |(m_st & m_mask);
        case (m_mode)
            2'b01:   return {~p, 1'b1};
            2'b10:   return {1'b0, p};
            default: return {p, 1'b1};
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bus cycle: drive, compare pre-edge outputs, advance model
    task automatic cyc(input logic [7:0] a, input logic r, input logic w,
                       input logic [7:0] d, input logic u, input logic o,
                       input string req);
        logic [7:0] ev;
        logic [7:0] keep;
        @(negedge clk);
        reg_addr = a; reg_rd = r; reg_wr = w; reg_wdata = d;
        lock_lost = u; over_range = o;
        #1;
        check({req, " pin R8/R9/R10/R11"}, {6'b0, irq_o, irq_oe}, {6'b0, exp_pin()});
        if (r) check({req, " rdata"}, reg_rdata, exp_rd(a));
        ev = {u, 5'b0, o, 1'b0};
        keep = (r && a == 8'h20) ? 8'h00 : m_st;
        m_st = (keep | ev) & m_mask & 8'h82;
        if (w && a == 8'h21) m_mask = d & 8'h82;
        if (w && a == 8'h22) m_mode = d[1:0];
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(posedge clk);
        #1;
        check("R4 reset rdata idle", reg_rdata, 8'h00);
        rst_n = 1'b1;
        // reset values (R4, R6, R7)
        cyc(8'h20, 1, 0, 8'h00, 0, 0, "R4 reset status");
        cyc(8'h21, 1, 0, 8'h00, 0, 0, "R6 reset mask");
        cyc(8'h22, 1, 0, 8'h00, 0, 0, "R7 reset mode");
        // masked-off sources never latch (R3)
        cyc(8'h00, 0, 0, 8'h00, 1, 1, "R3 masked event");
        cyc(8'h20, 1, 0, 8'h00, 0, 0, "R3 masked read");
        // writable mask bits only (R6), status ignores writes (R4)
        cyc(8'h21, 0, 1, 8'hFF, 0, 0, "R6 write mask");
        cyc(8'h21, 1, 0, 8'h00, 0, 0, "R6 mask readback");
        cyc(8'h20, 0, 1, 8'hFF, 0, 0, "R4 write status");
        cyc(8'h20, 1, 0, 8'h00, 0, 0, "R4 status after write");
        // sticky set and non-clearing reads (R1, R2, R11)
        cyc(8'h00, 0, 0, 8'h00, 1, 0, "R11 lock event");
        cyc(8'h21, 1, 0, 8'h00, 0, 0, "R2 other read");
        cyc(8'h22, 1, 0, 8'h00, 0, 0, "R1 sticky hold");
        cyc(8'h20, 1, 0, 8'h00, 0, 1, "R5 read with event");
        cyc(8'h20, 1, 0, 8'h00, 0, 0, "R5 survivor read");
        cyc(8'h20, 1, 0, 8'h00, 0, 0, "R2 cleared");
        // level held over a read re-sets (R12)
        cyc(8'h00, 0, 0, 8'h00, 0, 1, "R12 level on");
        cyc(8'h20, 1, 0, 8'h00, 0, 1, "R12 read while high");
        cyc(8'h20, 1, 0, 8'h00, 0, 0, "R12 re-set");
        // pin modes (R7, R8, R9, R10)
        foreach (m_st[k]) begin end
        for (int md = 0; md < 4; md++) begin
            cyc(8'h22, 0, 1, 8'(md), 0, 0, "R7 mode write");
            cyc(8'h22, 1, 0, 8'h00, 0, 0, "R7 mode readback");
            cyc(8'h00, 0, 0, 8'h00, 0, 0, "R8/R9/R10 idle pin");
            cyc(8'h00, 0, 0, 8'h00, 1, 0, "R8/R9/R10 event");
            cyc(8'h00, 0, 0, 8'h00, 0, 0, "R8/R9/R10 pending pin");
            cyc(8'h20, 1, 0, 8'h00, 0, 0, "R2 clear");
        end
        // mask dropped while flag set (R3)
        cyc(8'h00, 0, 0, 8'h00, 1, 0, "R3 set");
        cyc(8'h21, 0, 1, 8'h02, 0, 0, "R3 drop mask");
        cyc(8'h21, 0, 1, 8'h82, 0, 0, "R3 restore mask");
        cyc(8'h20, 1, 0, 8'h00, 0, 0, "R3 stays clear");
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] a;
            logic [7:0] d;
            int sel;
            sel = $urandom_range(0, 9);
            a = (sel < 5) ? 8'h20 : (sel < 7) ? 8'h21 : (sel < 9) ? 8'h22 : 8'($urandom);
            d = 8'($urandom);
            cyc(a, ($urandom_range(0, 9) < 3), ($urandom_range(0, 19) == 0), d,
                ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0),
                "R1/R2/R3/R5/R12 random");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule